// File: doc/BRIEF.md
# Tiered-Latency DRAM Bank Controller

This block sequences read accesses to one DRAM bank. The bank's rows are split into a fast near segment and a slow far segment. Each request carries a row address. The controller checks a small programmable table that says whether the row is served from the near segment. It then runs the activation, the data read and the precharge with that segment's timing. The bank works closed-row, so every access opens its row and closes it again. Each request reports the cycle count from its arrival to the point its data becomes available.

Requests that arrive while the bank is occupied wait in a short in-order queue. Software or a static setup sequence loads the row-to-segment table through a configuration port. A fixed budget limits how many rows may be near at once, and a write that would break this budget is refused and signalled. One clock cycle stands for 1 ns of DRAM time.

Top module: `tl_bank_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, cfg_reject is 0 and every row uses far timing.
- R2: When the bank is idle, a request to a near row gets a response whose rsp_lat is NEAR_RD+1 (default 11) cycles after the accepting edge, with rsp_near = 1.
- R3: When the bank is idle, a request to a far row gets a response whose rsp_lat is FAR_RD+1 (default 16), with rsp_near = 0.
- R4: Closed-row: two back-to-back requests to the same near row each pay a full activation. The second reports rsp_lat = 1 + NEAR_CYC + NEAR_RD - 1 (default 35).
- R5: A new activation starts no earlier than the full activate-plus-precharge interval (NEAR_CYC 25 or FAR_CYC 50) of the access in progress. A near request accepted one cycle after a far one reports rsp_lat = FAR_CYC + NEAR_RD (default 60).
- R6: Queued requests are served in arrival order. With an occupied bank, req_ready drops to 0 once FIFO_DEPTH requests are waiting, which is after 5 accepts by default.
- R7: A configuration write with cfg_near = 1 makes the row near. A write with cfg_near = 0 returns the row to far timing.
- R8: At most MAX_NEAR (2) rows are near. A write that would mark a further row near is refused and the table is left unchanged. cfg_reject is then 1 for exactly the one cycle after the write. Re-marking a row that is already near is accepted.
- R9: Row addresses at or above NUM_ROWS (6) are served with far timing. Configuration writes to them are refused with cfg_reject.
- R10: rsp_valid is a one-cycle pulse per request, and rsp_row returns the request's row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per ns |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Queue can take a request |
| req_row | input | ROW_W | Row address of the request |
| rsp_valid | output | 1 | Data-available pulse |
| rsp_row | output | ROW_W | Row of the completed request |
| rsp_near | output | 1 | Access used near timing |
| rsp_lat | output | LAT_W | Cycles from acceptance to data-available |
| cfg_we | input | 1 | Table write strobe |
| cfg_row | input | ROW_W | Row being configured |
| cfg_near | input | 1 | 1 = near, 0 = far |
| cfg_reject | output | 1 | Previous write was refused |

## Verification
On every cycle, the assertions check several things. The near budget is never exceeded, and a refused write leaves the table untouched. The queue never overflows or underflows. Responses are single-cycle pulses with a latency no lower than the near-segment floor. An activation never runs past its own interval. Only the bench's scenarios can show the exact latency values that come from the segment timings, closed-row repetition and the spacing between activations. The same holds for arrival-order service, back-pressure at a full queue, and the effect of configuration writes on later accesses.

// File: rtl/tl_bank_pkg.sv
package tl_bank_pkg;
  typedef enum logic {SEG_FAR = 1'b0, SEG_NEAR = 1'b1} seg_e;

  typedef struct packed {
    logic [7:0] rd;   // cycles from activation to data
    logic [7:0] cyc;  // activation plus precharge
  } seg_timing_t;
endpackage

// File: rtl/tl_seg_map.sv
module tl_seg_map
  import tl_bank_pkg::*;
#(
  parameter int NUM_ROWS = 6,
  parameter int ROW_W    = 3,
  parameter int MAX_NEAR = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [ROW_W-1:0] cfg_row,
  input  logic             cfg_near,
  output logic             cfg_reject,
  input  logic [ROW_W-1:0] lk_row,
  output seg_e             lk_seg
);
  localparam int CNT_W = $clog2(NUM_ROWS + 1);
  localparam logic [ROW_W:0] ROWS_L = (ROW_W+1)'(NUM_ROWS);
  localparam logic [CNT_W-1:0] MAX_L = CNT_W'(MAX_NEAR);

  logic [NUM_ROWS-1:0] near_map;
  logic [CNT_W-1:0]    near_cnt;
  logic                cfg_in_range, lk_in_range, cur_near, accept;

  assign cfg_in_range = {1'b0, cfg_row} < ROWS_L;
  assign lk_in_range  = {1'b0, lk_row} < ROWS_L;
  assign cur_near     = cfg_in_range && near_map[cfg_row];
  assign accept       = cfg_in_range && (!cfg_near || cur_near || near_cnt < MAX_L);
  assign lk_seg       = (lk_in_range && near_map[lk_row]) ? SEG_NEAR : SEG_FAR;

  always_ff @(posedge clk) begin
    if (rst) begin
      near_map   <= '0;
      near_cnt   <= '0;
      cfg_reject <= 1'b0;
    end else begin
      cfg_reject <= cfg_we && !accept;
      if (cfg_we && accept && (cur_near != cfg_near)) begin
        near_map[cfg_row] <= cfg_near;
        near_cnt <= cfg_near ? near_cnt + 1'b1 : near_cnt - 1'b1;
      end
    end
  end

  assert_near_limit_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(near_map) <= MAX_NEAR);

  assert_reject_keeps_map_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_reject |-> $stable(near_map));
endmodule

// File: rtl/tl_req_fifo.sv
module tl_req_fifo #(
  parameter int W     = 13,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULL_L = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;

  assign full    = count == FULL_L;
  assign empty   = count == '0;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (wr_en && !rd_en)      count <= count + 1'b1;
      else if (rd_en && !wr_en) count <= count - 1'b1;
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && full));

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && empty));
endmodule

// File: rtl/tl_bank_seq.sv
module tl_bank_seq
  import tl_bank_pkg::*;
#(
  parameter int ROW_W    = 3,
  parameter int LAT_W    = 10,
  parameter int NEAR_RD  = 10,
  parameter int NEAR_CYC = 25,
  parameter int FAR_RD   = 15,
  parameter int FAR_CYC  = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             q_empty,
  input  logic [ROW_W-1:0] q_row,
  input  logic [LAT_W-1:0] q_stamp,
  input  seg_e             q_seg,
  input  logic [LAT_W-1:0] now,
  output logic             q_pop,
  output logic             rsp_valid,
  output logic [ROW_W-1:0] rsp_row,
  output logic             rsp_near,
  output logic [LAT_W-1:0] rsp_lat
);
  localparam seg_timing_t TIM_NEAR = '{rd: 8'(NEAR_RD), cyc: 8'(NEAR_CYC)};
  localparam seg_timing_t TIM_FAR  = '{rd: 8'(FAR_RD),  cyc: 8'(FAR_CYC)};

  logic             busy, cur_near;
  logic [7:0]       cnt;
  seg_timing_t      cur_tim, tim_sel;
  logic [ROW_W-1:0] cur_row;
  logic [LAT_W-1:0] cur_stamp;
  logic             data_hit, done_cyc;

  assign tim_sel  = (q_seg == SEG_NEAR) ? TIM_NEAR : TIM_FAR;
  assign data_hit = busy && cnt == cur_tim.rd;
  assign done_cyc = busy && cnt == cur_tim.cyc;
  assign q_pop    = (!busy || done_cyc) && !q_empty;

  always_ff @(posedge clk) begin
    if (q_pop) begin
      cur_tim   <= tim_sel;
      cur_row   <= q_row;
      cur_stamp <= q_stamp;
      cur_near  <= q_seg == SEG_NEAR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      rsp_valid <= 1'b0;
      rsp_row   <= '0;
      rsp_near  <= 1'b0;
      rsp_lat   <= '0;
    end else begin
      rsp_valid <= data_hit;
      if (data_hit) begin
        rsp_lat  <= now - cur_stamp;
        rsp_row  <= cur_row;
        rsp_near <= cur_near;
      end
      if (q_pop) begin
        busy <= 1'b1;
        cnt  <= 8'd1;
      end else if (done_cyc) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + 8'd1;
      end
    end
  end

  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_lat_floor_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_lat >= LAT_W'(NEAR_RD + 1));

  assert_interval_bound_R5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt >= 8'd1 && cnt <= cur_tim.cyc));
endmodule

// File: rtl/tl_bank_ctrl.sv
module tl_bank_ctrl
  import tl_bank_pkg::*;
#(
  parameter int NUM_ROWS   = 6,
  parameter int ROW_W      = 3,
  parameter int MAX_NEAR   = 2,
  parameter int FIFO_DEPTH = 4,
  parameter int LAT_W      = 10,
  parameter int NEAR_RD    = 10,
  parameter int NEAR_CYC   = 25,
  parameter int FAR_RD     = 15,
  parameter int FAR_CYC    = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  output logic             rsp_valid,
  output logic [ROW_W-1:0] rsp_row,
  output logic             rsp_near,
  output logic [LAT_W-1:0] rsp_lat,
  input  logic             cfg_we,
  input  logic [ROW_W-1:0] cfg_row,
  input  logic             cfg_near,
  output logic             cfg_reject
);
  localparam int ENTRY_W = ROW_W + LAT_W;

  logic [LAT_W-1:0]   now;
  logic               q_full, q_empty, q_pop, q_push;
  logic [ENTRY_W-1:0] q_out;
  seg_e               q_seg;

  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else     now <= now + 1'b1;
  end

  assign req_ready = !q_full;
  assign q_push    = req_valid && req_ready;

  tl_req_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .wr_en(q_push), .wr_data({req_row, now}), .full(q_full),
    .rd_en(q_pop), .rd_data(q_out), .empty(q_empty)
  );

  tl_seg_map #(.NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W), .MAX_NEAR(MAX_NEAR)) u_map (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_near(cfg_near), .cfg_reject(cfg_reject),
    .lk_row(q_out[ENTRY_W-1 -: ROW_W]), .lk_seg(q_seg)
  );

  tl_bank_seq #(
    .ROW_W(ROW_W), .LAT_W(LAT_W),
    .NEAR_RD(NEAR_RD), .NEAR_CYC(NEAR_CYC), .FAR_RD(FAR_RD), .FAR_CYC(FAR_CYC)
  ) u_seq (
    .clk(clk), .rst(rst),
    .q_empty(q_empty), .q_row(q_out[ENTRY_W-1 -: ROW_W]), .q_stamp(q_out[LAT_W-1:0]),
    .q_seg(q_seg), .now(now), .q_pop(q_pop),
    .rsp_valid(rsp_valid), .rsp_row(rsp_row), .rsp_near(rsp_near), .rsp_lat(rsp_lat)
  );
endmodule

// File: tb/tb_tl_bank_ctrl.sv
`timescale 1ns/1ps
module tb_tl_bank_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_row = '0;
  logic       rsp_valid;
  logic [2:0] rsp_row;
  logic       rsp_near;
  logic [9:0] rsp_lat;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_row = '0;
  logic       cfg_near = 1'b0;
  logic       cfg_reject;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tl_bank_ctrl dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_row(req_row),
    .rsp_valid(rsp_valid), .rsp_row(rsp_row), .rsp_near(rsp_near), .rsp_lat(rsp_lat),
    .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_near(cfg_near), .cfg_reject(cfg_reject)
  );

  // response log sampled away from the active edge
  int         nrsp = 0;
  logic [2:0] log_row  [32];
  logic       log_near [32];
  logic [9:0] log_lat  [32];
  always @(negedge clk) begin
    if (!rst && rsp_valid && nrsp < 32) begin
      log_row[nrsp]  = rsp_row;
      log_near[nrsp] = rsp_near;
      log_lat[nrsp]  = rsp_lat;
      nrsp++;
    end
  end

  // {row, near, latency}; rows 1 and 4 near, 6 and 7 beyond the table
  localparam logic [13:0] VEC [8] = '{
    {3'd0, 1'b0, 10'd16}, {3'd1, 1'b1, 10'd11}, {3'd2, 1'b0, 10'd16},
    {3'd3, 1'b0, 10'd16}, {3'd4, 1'b1, 10'd11}, {3'd5, 1'b0, 10'd16},
    {3'd6, 1'b0, 10'd16}, {3'd7, 1'b0, 10'd16}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfg(input logic [2:0] row, input logic nr, input int exp_rej, input string req);
    @(negedge clk);
    cfg_we = 1'b1; cfg_row = row; cfg_near = nr;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(req, int'(cfg_reject), exp_rej);
    @(negedge clk);
    chk(req, int'(cfg_reject), 0);
  endtask

  task automatic single(input logic [2:0] row, input int exp_near, input int exp_lat, input string req);
    int base;
    base = nrsp;
    @(negedge clk);
    req_valid = 1'b1; req_row = row;
    @(negedge clk);
    req_valid = 1'b0;
    wait_cyc(60);
    chk(req, nrsp - base, 1);
    chk(req, int'(log_row[base]), int'(row));
    chk(req, int'(log_near[base]), exp_near);
    chk(req, int'(log_lat[base]), exp_lat);
  endtask

  task automatic pair(input logic [2:0] ra, input logic [2:0] rb, input int la, input int lb, input string req);
    int base;
    base = nrsp;
    @(negedge clk);
    req_valid = 1'b1; req_row = ra;
    @(negedge clk);
    req_row = rb;
    @(negedge clk);
    req_valid = 1'b0;
    wait_cyc(130);
    chk(req, nrsp - base, 2);
    chk(req, int'(log_lat[base]), la);
    chk(req, int'(log_lat[base+1]), lb);
  endtask

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(req_ready), 1);
    chk("R1", int'(rsp_valid), 0);
    chk("R1", int'(cfg_reject), 0);
    single(3'd1, 0, 16, "R1");

    // configuration: R7, R8, R9
    cfg(3'd1, 1'b1, 0, "R7");
    cfg(3'd4, 1'b1, 0, "R7");
    cfg(3'd2, 1'b1, 1, "R8");
    cfg(3'd1, 1'b1, 0, "R8");
    cfg(3'd7, 1'b1, 1, "R9");
    single(3'd2, 0, 16, "R8");

    // vector table: R2, R3, R9, R10
    for (int i = 0; i < 8; i++) begin
      single(VEC[i][13:11], int'(VEC[i][10]), int'(VEC[i][9:0]),
             VEC[i][10] ? "R2" : (VEC[i][13:11] >= 3'd6 ? "R9" : "R3"));
    end

    // R7: release and re-mark
    cfg(3'd4, 1'b0, 0, "R7");
    single(3'd4, 0, 16, "R7");
    cfg(3'd2, 1'b1, 0, "R7");
    single(3'd2, 1, 11, "R7");

    // R4 closed-row repetition, R5 spacing after far access
    pair(3'd1, 3'd1, 11, 35, "R4");
    pair(3'd0, 3'd1, 16, 60, "R5");

    // R6 back-pressure and order
    begin
      int base, acc;
      logic [2:0] rows [6];
      rows = '{3'd0, 3'd3, 3'd5, 3'd1, 3'd4, 3'd2};
      base = nrsp;
      acc = 0;
      @(negedge clk);
      for (int c = 0; c < 10 && acc < 6; c++) begin
        req_valid = 1'b1; req_row = rows[acc];
        if (req_ready) begin
          @(negedge clk);
          acc++;
        end else begin
          @(negedge clk);
        end
      end
      req_valid = 1'b0;
      chk("R6", acc, 5);
      chk("R6", int'(req_ready), 0);
      wait_cyc(320);
      chk("R6", nrsp - base, 5);
      for (int k = 0; k < 5; k++) chk("R6", int'(log_row[base+k]), int'(rows[k]));
      chk("R6", int'(req_ready), 1);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule